// File: doc/BRIEF.md
# Strobe-Decoupled Word Serializer

This block turns 12-bit parallel words into a framed serial bit stream with a forwarded bit clock. A word is taken in on the rising edge of a strobe that has no fixed phase relation to the frame clock. Each frame is 14 bit slots long. When no word is waiting at a frame boundary, the frame goes out as all-zero idle fill. A divide select stretches every slot to one, two or three bit-slot enables, so the serial rate can follow a strobe that runs much slower than the reference.

The system clock stands in for the multiplied reference, and `bit_en` marks the bit-slot instants. The strobe passes through a two-flop synchronizer and a rising-edge detector. It is gated off while the PLL does not report lock. A captured word waits in a one-deep holding register until the next frame boundary. If a second word arrives while one is still waiting, a sticky overrun flag is set. Power-down clears the block to its reset state.

Top module: `word_serializer`

## Requirements
- R1: While reset is held, `ser_out`, `bit_clk` and `overrun` are all 0.
- R2: A frame has 14 slots, sent in this order: one marker bit, then the 12 data bits MSB first, then a stop bit that is always 0.
- R3: A frame that starts with no word pending carries 0 in all 14 slots.
- R4: `bit_clk` toggles once per slot and is 1 in slot 0 of every frame, which gives 7 rising edges per frame.
- R5: A rising strobe edge captures `din` after a two-flop synchronizer. The word goes out in the next frame that starts, marked by a 1 in the marker slot, and each strobe gives exactly one such frame.
- R6: A strobe edge that arrives while `pll_lock` is 0 is ignored. It produces no marked frame and does not set `overrun`.
- R7: `div_sel` sets how many `bit_en` pulses make up one slot: 2'b00 gives 1, 2'b01 gives 2, and 2'b10 or 2'b11 gives 3.
- R8: A strobe edge that arrives while a word is still pending sets `overrun`, which then stays set. The pending word is sent and the new word is dropped.
- R9: `pwr_down` clears the pending word and `overrun` and holds `ser_out` and `bit_clk` at 0. After release, framing restarts with no leftover word.
- R10: An all-zero data word is still sent with the marker set to 1, so a receiver can tell it apart from idle fill.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, stands in for the multiplied reference |
| rst_n | input | 1 | Asynchronous active-low reset |
| pwr_down | input | 1 | Synchronous power-down, clears all state |
| pll_lock | input | 1 | Lock indication; strobes are ignored while it is low |
| div_sel | input | 2 | Reference divide select: 00 none, 01 by 2, 1x by 3 |
| bit_en | input | 1 | Bit-slot enable pulse |
| strobe | input | 1 | Asynchronous word strobe, active on its rising edge |
| din | input | 12 | Parallel data word |
| ser_out | output | 1 | Serial frame data |
| bit_clk | output | 1 | Forwarded bit clock, toggles once per slot |
| overrun | output | 1 | Sticky flag: a word was lost |

## Verification
The bench decodes every frame it sees on the outputs. It looks for a real zero word that would be lost among the idle fill, a design that would leave its marker low on such a word. It aligns two strobes inside one frame: a design that overwrites the pending word sends the second value and skips the first, and one that does not flag the overrun never raises `overrun`. Strobes sent before lock and a word caught by power-down must produce no marked frame. A divider that miscounts shows up as slots with the wrong number of `bit_en` pulses.

// File: rtl/ws_pkg.sv
`timescale 1ns/1ps
package ws_pkg;
  typedef enum logic [1:0] {
    DIV_NONE = 2'b00,
    DIV_BY2  = 2'b01,
    DIV_BY3  = 2'b10,
    DIV_BY3B = 2'b11
  } div_sel_e;

  localparam int unsigned FRAME_OVERHEAD = 2;

  function automatic logic [1:0] div_last(input logic [1:0] sel);
    case (div_sel_e'(sel))
      DIV_NONE: div_last = 2'd0;
      DIV_BY2:  div_last = 2'd1;
      default:  div_last = 2'd2;
    endcase
  endfunction
endpackage

// File: rtl/ws_strobe_sync.sv
`timescale 1ns/1ps
module ws_strobe_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic strobe_async,
  output logic rise
);
  logic [STAGES:0] chain_q;
  logic [STAGES:0] chain_n;

  always_comb begin
    chain_n = {chain_q[STAGES-1:0], strobe_async};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   chain_q <= '0;
    else if (clr) chain_q <= '0;
    else          chain_q <= chain_n;
  end

  assign rise = chain_q[STAGES-1] & ~chain_q[STAGES];

  // R5: one synchronized edge gives a single-cycle pulse
  assert_rise_single_R5: assert property (@(posedge clk) disable iff (!rst_n)
    rise |=> !rise);
endmodule

// File: rtl/ws_word_hold.sv
`timescale 1ns/1ps
module ws_word_hold #(
  parameter int W = 12
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         lock,
  input  logic         rise,
  input  logic [W-1:0] din,
  input  logic         take,
  output logic         pend,
  output logic [W-1:0] word,
  output logic         overrun
);
  logic         pend_q, pend_n;
  logic [W-1:0] word_q, word_n;
  logic         ovr_q, ovr_n;
  logic         cap;

  always_comb begin
    cap    = rise & lock;
    pend_n = pend_q;
    word_n = word_q;
    ovr_n  = ovr_q;
    if (take) pend_n = 1'b0;
    if (cap) begin
      if (pend_q && !take) begin
        ovr_n = 1'b1;
      end else begin
        pend_n = 1'b1;
        word_n = din;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= 1'b0;
      word_q <= '0;
      ovr_q  <= 1'b0;
    end else if (clr) begin
      pend_q <= 1'b0;
      word_q <= '0;
      ovr_q  <= 1'b0;
    end else begin
      pend_q <= pend_n;
      word_q <= word_n;
      ovr_q  <= ovr_n;
    end
  end

  assign pend    = pend_q;
  assign word    = word_q;
  assign overrun = ovr_q;

  assert_overrun_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (ovr_q && !clr) |=> ovr_q);
  assert_lock_gate_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!lock && !pend_q) |=> !pend_q);
  assert_capture_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (rise && lock && !pend_q && !clr) |=> pend_q);
endmodule

// File: rtl/ws_slot_timer.sv
`timescale 1ns/1ps
module ws_slot_timer
  import ws_pkg::*;
#(
  parameter int SLOTS = 14,
  parameter int IDX_W = $clog2(SLOTS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             bit_en,
  input  logic [1:0]       div_sel,
  output logic             slot_tick,
  output logic             frame_start,
  output logic [IDX_W-1:0] slot_idx
);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(SLOTS - 1);

  logic [1:0]       div_q, div_n;
  logic [IDX_W-1:0] slot_q, slot_n;
  logic [1:0]       lim;
  logic             tick;

  always_comb begin
    lim    = div_last(div_sel);
    tick   = bit_en && (div_q >= lim);
    div_n  = div_q;
    slot_n = slot_q;
    if (bit_en) div_n = tick ? 2'd0 : div_q + 2'd1;
    if (tick)   slot_n = (slot_q == LAST_IDX) ? '0 : slot_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      div_q  <= 2'd0;
      slot_q <= LAST_IDX;
    end else if (clr) begin
      div_q  <= 2'd0;
      slot_q <= LAST_IDX;
    end else begin
      div_q  <= div_n;
      slot_q <= slot_n;
    end
  end

  assign slot_tick   = tick;
  assign frame_start = tick && (slot_q == LAST_IDX);
  assign slot_idx    = slot_q;

  assert_div_bound_R7: assert property (@(posedge clk) disable iff (!rst_n)
    div_q <= 2'd2);
  assert_slot_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!bit_en && !clr) |=> $stable(slot_q));
endmodule

// File: rtl/ws_frame_shift.sv
`timescale 1ns/1ps
module ws_frame_shift #(
  parameter int W = 12,
  parameter int FR_W = W + ws_pkg::FRAME_OVERHEAD
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         slot_tick,
  input  logic         frame_start,
  input  logic         pend,
  input  logic [W-1:0] word,
  output logic         ser_out,
  output logic         bit_clk
);
  logic [FR_W-1:0] sh_q, sh_n;
  logic            bc_q, bc_n;

  always_comb begin
    sh_n = sh_q;
    bc_n = bc_q;
    if (frame_start) begin
      sh_n = pend ? {1'b1, word, 1'b0} : '0;
      bc_n = 1'b1;
    end else if (slot_tick) begin
      sh_n = {sh_q[FR_W-2:0], 1'b0};
      bc_n = ~bc_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q <= '0;
      bc_q <= 1'b0;
    end else if (clr) begin
      sh_q <= '0;
      bc_q <= 1'b0;
    end else begin
      sh_q <= sh_n;
      bc_q <= bc_n;
    end
  end

  assign ser_out = sh_q[FR_W-1];
  assign bit_clk = bc_q;

  assert_pd_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (!ser_out && !bit_clk));
endmodule

// File: rtl/word_serializer.sv
`timescale 1ns/1ps
module word_serializer #(
  parameter int DATA_W      = 12,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pwr_down,
  input  logic              pll_lock,
  input  logic [1:0]        div_sel,
  input  logic              bit_en,
  input  logic              strobe,
  input  logic [DATA_W-1:0] din,
  output logic              ser_out,
  output logic              bit_clk,
  output logic              overrun
);
  localparam int SLOTS = DATA_W + ws_pkg::FRAME_OVERHEAD;
  localparam int IDX_W = $clog2(SLOTS);

  logic              rise;
  logic              pend;
  logic [DATA_W-1:0] word;
  logic              slot_tick;
  logic              frame_start;
  logic [IDX_W-1:0]  slot_idx;

  ws_strobe_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .clr(pwr_down),
    .strobe_async(strobe), .rise(rise)
  );

  ws_word_hold #(.W(DATA_W)) u_hold (
    .clk(clk), .rst_n(rst_n), .clr(pwr_down), .lock(pll_lock),
    .rise(rise), .din(din), .take(frame_start),
    .pend(pend), .word(word), .overrun(overrun)
  );

  ws_slot_timer #(.SLOTS(SLOTS), .IDX_W(IDX_W)) u_timer (
    .clk(clk), .rst_n(rst_n), .clr(pwr_down), .bit_en(bit_en),
    .div_sel(div_sel), .slot_tick(slot_tick),
    .frame_start(frame_start), .slot_idx(slot_idx)
  );

  ws_frame_shift #(.W(DATA_W)) u_shift (
    .clk(clk), .rst_n(rst_n), .clr(pwr_down), .slot_tick(slot_tick),
    .frame_start(frame_start), .pend(pend), .word(word),
    .ser_out(ser_out), .bit_clk(bit_clk)
  );

  assert_stop_low_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (slot_idx == IDX_W'(SLOTS - 1)) |-> !ser_out);
  assert_bitclk_toggle_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (slot_tick && !pwr_down) |=> (bit_clk != $past(bit_clk)));
  assert_marker_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_start && pend && !pwr_down) |=> ser_out);
  assert_idle_fill_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_start && !pend && !pwr_down) |=> !ser_out);
endmodule

// File: tb/test_word_serializer.sv
`timescale 1ns/1ps
module test_word_serializer;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        pwr_down = 1'b0;
  logic        pll_lock = 1'b0;
  logic [1:0]  div_sel = 2'b00;
  logic        bit_en = 1'b0;
  logic        strobe = 1'b0;
  logic [11:0] din = '0;
  logic        ser_out, bit_clk, overrun;

  int total = 0;
  int bad = 0;
  bit done = 0;
  bit en_full = 0;

  logic [13:0] rx_q[$];
  logic [11:0] exp_q[$];
  int          nslot = 0;
  int          bclk_bad = 0;
  logic        prev_bc = 1'b0;
  logic [13:0] cur = '0;

  always #2 clk = ~clk;

  word_serializer i_word_serializer (
    .clk(clk), .rst_n(rst_n), .pwr_down(pwr_down), .pll_lock(pll_lock),
    .div_sel(div_sel), .bit_en(bit_en), .strobe(strobe), .din(din),
    .ser_out(ser_out), .bit_clk(bit_clk), .overrun(overrun)
  );

  always @(posedge clk) bit_en <= en_full ? 1'b1 : (($urandom % 4) != 0);

  // frame monitor: one bit_clk change per slot
  always @(negedge clk) begin
    if (!rst_n || pwr_down) begin
      prev_bc = 1'b0;
      nslot   = 0;
      cur     = '0;
    end else if (bit_clk != prev_bc) begin
      prev_bc = bit_clk;
      if ((nslot % 14) == 0 && !bit_clk) bclk_bad++;
      cur = {cur[12:0], ser_out};
      nslot++;
      if ((nslot % 14) == 0) rx_q.push_back(cur);
    end
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic send_word(input logic [11:0] w);
    step();
    din = w;
    strobe = 1'b1;
    repeat (3) step();
    strobe = 1'b0;
    repeat (3) step();
  endtask

  task automatic align_frame();
    do @(posedge clk); while ((nslot % 14) != 1);
    #1;
  endtask

  task automatic check_frames(input string tag);
    int k = 0;
    foreach (rx_q[i]) begin
      logic [13:0] f;
      f = rx_q[i];
      if (f[13]) begin
        if (k < exp_q.size())
          chk(f[12:1] == exp_q[k], {tag, " R2/R5/R10 data"}, f[12:1], exp_q[k]);
        else
          chk(1'b0, {tag, " R5 extra word"}, f[12:1], 0);
        chk(f[0] == 1'b0, {tag, " R2 stop bit"}, f[0], 0);
        k++;
      end else begin
        chk(f == 14'd0, {tag, " R3 idle fill"}, f, 0);
      end
    end
    chk(k == exp_q.size(), {tag, " R5 word count"}, k, exp_q.size());
  endtask

  task automatic measure_slot(output int n);
    logic pb;
    bit started;
    started = 0;
    n = 0;
    @(negedge clk);
    pb = bit_clk;
    while (1) begin
      @(negedge clk);
      if (bit_clk != pb) begin
        pb = bit_clk;
        if (started) break;
        started = 1;
        n = 0;
      end
      if (started && bit_en) n++;
    end
  endtask

  initial begin
    int n;
    void'($urandom(32'd20240611));
    // R1: reset state
    repeat (5) @(negedge clk);
    chk(ser_out == 1'b0, "R1 ser_out", ser_out, 0);
    chk(bit_clk == 1'b0, "R1 bit_clk", bit_clk, 0);
    chk(overrun == 1'b0, "R1 overrun", overrun, 0);
    step();
    rst_n = 1'b1;
    repeat (40) step();

    // R6: strobes before lock are ignored
    rx_q.delete(); exp_q.delete();
    for (int i = 0; i < 3; i++) begin
      send_word(12'h3C3 + 12'(i));
      repeat (40) step();
    end
    repeat (60) step();
    check_frames("R6 unlocked");
    @(negedge clk);
    chk(overrun == 1'b0, "R6 overrun", overrun, 0);

    // R2/R3/R5/R10: words at divide none
    pll_lock = 1'b1;
    repeat (10) step();
    rx_q.delete(); exp_q.delete();
    exp_q.push_back(12'hA5C); send_word(12'hA5C); repeat (60) step();
    exp_q.push_back(12'h000); send_word(12'h000); repeat (60) step();
    exp_q.push_back(12'hFFF); send_word(12'hFFF); repeat (60) step();
    exp_q.push_back(12'h801); send_word(12'h801); repeat (60) step();
    for (int i = 0; i < 10; i++) begin
      logic [11:0] w;
      w = 12'($urandom % 4096);
      exp_q.push_back(w);
      send_word(w);
      repeat (60) step();
    end
    repeat (80) step();
    check_frames("words div1");

    // R7: slot length per divide select
    for (int d = 0; d < 4; d++) begin
      step();
      div_sel = 2'(d);
      measure_slot(n);
      measure_slot(n);
      chk(n == ((d == 0) ? 1 : (d == 1) ? 2 : 3), "R7 slot length", n,
          (d == 0) ? 1 : (d == 1) ? 2 : 3);
    end

    // words at divide by 3
    step();
    div_sel = 2'b10;
    repeat (200) step();
    rx_q.delete(); exp_q.delete();
    exp_q.push_back(12'h5A5); send_word(12'h5A5); repeat (200) step();
    exp_q.push_back(12'h000); send_word(12'h000); repeat (200) step();
    check_frames("words div3");

    // R8: two strobes inside one frame
    en_full = 1'b1;
    repeat (100) step();
    rx_q.delete(); exp_q.delete();
    align_frame();
    exp_q.push_back(12'h1E7);
    send_word(12'h1E7);
    send_word(12'h6B2);
    @(negedge clk);
    chk(overrun == 1'b1, "R8 overrun set", overrun, 1);
    repeat (150) step();
    check_frames("R8 overrun");
    @(negedge clk);
    chk(overrun == 1'b1, "R8 overrun sticky", overrun, 1);

    // R9: power-down drops the pending word and the flag
    align_frame();
    send_word(12'h777);
    pwr_down = 1'b1;
    repeat (2) step();
    @(negedge clk);
    chk(ser_out == 1'b0, "R9 ser_out", ser_out, 0);
    chk(bit_clk == 1'b0, "R9 bit_clk", bit_clk, 0);
    chk(overrun == 1'b0, "R9 overrun cleared", overrun, 0);
    step();
    pwr_down = 1'b0;
    rx_q.delete(); exp_q.delete();
    repeat (200) step();
    check_frames("R9 after power-down");
    rx_q.delete(); exp_q.delete();
    exp_q.push_back(12'h0F0); send_word(12'h0F0); repeat (150) step();
    check_frames("R9 restart");

    chk(bclk_bad == 0, "R4 bit_clk high in slot 0", bclk_bad, 0);

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog act=0 exp=1");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule